// File: doc/BRIEF.md
# Display Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe, a one-cycle frame-start pulse and the current pixel column and line. Each line is counted in pixel clocks through four phases: visible pixels, front porch, sync pulse and back porch. The line count steps through the same four phases, one step per finished line. Every phase length is a run-time input. The generator copies these lengths into shadow registers only at a frame boundary, so a new setting takes effect cleanly at the next frame.

Each control output has its own polarity bit and its own enable bit. The data-enable output can be launched on either edge of the pixel clock. The two sync outputs have a separate launch-edge choice, and a qualifying flag makes them follow the data edge when the flag is clear. While the run input is low the counters sit at the frame origin and every control output is at its inactive level. The first clock edge that sees run high presents the origin pixel.

Top module: `display_timing_gen`

## Requirements
- R1: Once running, `col` steps by one each clock from 0 to line_total-1 and then returns to 0. line_total = h_act + h_fp + h_sync + h_bp. The visible pixels are columns 0..h_act-1, followed by the front porch, then the sync pulse, then the back porch.
- R2: The horizontal sync is asserted for exactly the columns h_act+h_fp through h_act+h_fp+h_sync-1.
- R3: `row` advances by one in the clock where `col` returns to 0 and wraps to 0 after frame_total-1 (the sum of the four vertical lengths). The vertical sync is asserted for rows v_act+v_fp through v_act+v_fp+v_sync-1, and it changes only together with the column wrap.
- R4: Data enable is asserted only when col < h_act and row < v_act.
- R5: A polarity bit of 1 makes its output high when asserted and low otherwise. A polarity bit of 0 inverts this.
- R6: When an output's enable bit is 0, that output stays at its inactive level (the inverse of its polarity bit).
- R7: `data_edge` = 1 launches data enable on the rising clock edge. `data_edge` = 0 launches it on the falling edge, half a cycle after the rising-edge value, so that just after a rising edge it still shows the previous cycle's value.
- R8: The sync outputs use `sync_edge` with the same encoding when `sync_edge_valid` = 1, and use `data_edge` when `sync_edge_valid` = 0.
- R9: A change to any phase-length input during a frame does not affect that frame. It takes effect from the first pixel of the next frame.
- R10: `frame_start` is high for exactly one clock, in the cycle where col = 0 and row = 0 while running.
- R11: After reset, and on the clock after run is seen low, col = 0, row = 0, `frame_start` = 0 and all control outputs are inactive. The first rising edge with run high presents col = 0, row = 0.
- R12: Every phase length of 1 (the minimum) gives a 4-clock line and a 4-line frame with correct sync and enable placement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Generator runs while high, rewinds to the origin while low |
| h_act | input | W_H | Visible pixels per line |
| h_fp | input | W_H | Horizontal front porch, pixels |
| h_sync | input | W_H | Horizontal sync width, pixels |
| h_bp | input | W_H | Horizontal back porch, pixels |
| v_act | input | W_V | Visible lines per frame |
| v_fp | input | W_V | Vertical front porch, lines |
| v_sync | input | W_V | Vertical sync width, lines |
| v_bp | input | W_V | Vertical back porch, lines |
| pol_hs | input | 1 | Horizontal sync polarity (1 = active high) |
| pol_vs | input | 1 | Vertical sync polarity (1 = active high) |
| pol_de | input | 1 | Data-enable polarity (1 = active high) |
| en_hs | input | 1 | Horizontal sync output enable |
| en_vs | input | 1 | Vertical sync output enable |
| en_de | input | 1 | Data-enable output enable |
| data_edge | input | 1 | Data launch edge: 1 rising, 0 falling |
| sync_edge | input | 1 | Sync launch edge: 1 rising, 0 falling |
| sync_edge_valid | input | 1 | 1: sync uses sync_edge; 0: sync uses data_edge |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| frame_start | output | 1 | One-clock pulse at the frame origin |
| col | output | W_H+2 | Current pixel column |
| row | output | W_V+2 | Current line |

## Verification
If the horizontal counter goes wrong, `col` departs from the expected ramp in the very next cycle, and the sync and enable pulses slide with it. If the vertical counter or the shadow copy goes wrong, the error may stay hidden until the next column wrap or frame boundary, so the bench runs complete frames. It also checks the cycles just after a frame boundary, where newly loaded lengths first matter. A wrong launch-edge choice shows as a half-cycle shift: just after a rising edge, a falling-edge output must still carry the previous cycle's level.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } launch_edge_e;

  // Level seen on a control pin given its logical state, enable and polarity.
  function automatic logic drive_level(input logic asserted, input logic enable,
                                       input logic polarity);
    return (asserted & enable) ? polarity : ~polarity;
  endfunction

endpackage

// File: rtl/tgen_axis.sv
module tgen_axis #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic [CW-1:0] len_act,
  input  logic [CW-1:0] len_fp,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_bp,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] nxt,
  output logic          at_end,
  output logic          nxt_act,
  output logic          nxt_sync
);
  logic [CW-1:0] sync_lo, sync_hi, total;

  always_comb begin
    sync_lo = len_act + len_fp;
    sync_hi = sync_lo + len_sync;
    total   = sync_hi + len_bp;
    at_end  = (cnt == total - CW'(1));
    if (clear)      nxt = '0;
    else if (!step) nxt = cnt;
    else if (at_end) nxt = '0;
    else            nxt = cnt + CW'(1);
    nxt_act  = (nxt < len_act);
    nxt_sync = (nxt >= sync_lo) && (nxt < sync_hi);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt;
  end
endmodule

// File: rtl/tgen_launch.sv
module tgen_launch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  input  logic [N-1:0] rst_val,
  input  logic [N-1:0] on_rise,
  output logic [N-1:0] q
);
  logic [N-1:0] q_fall;

  always_ff @(negedge clk) begin
    if (rst) q_fall <= rst_val;
    else     q_fall <= d;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign q[i] = on_rise[i] ? d[i] : q_fall[i];
  end
endmodule

// File: rtl/display_timing_gen.sv
module display_timing_gen
  import tgen_pkg::*;
#(
  parameter int W_H = 12,
  parameter int W_V = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [W_H-1:0]   h_act,
  input  logic [W_H-1:0]   h_fp,
  input  logic [W_H-1:0]   h_sync,
  input  logic [W_H-1:0]   h_bp,
  input  logic [W_V-1:0]   v_act,
  input  logic [W_V-1:0]   v_fp,
  input  logic [W_V-1:0]   v_sync,
  input  logic [W_V-1:0]   v_bp,
  input  logic             pol_hs,
  input  logic             pol_vs,
  input  logic             pol_de,
  input  logic             en_hs,
  input  logic             en_vs,
  input  logic             en_de,
  input  logic             data_edge,
  input  logic             sync_edge,
  input  logic             sync_edge_valid,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             frame_start,
  output logic [W_H+1:0]   col,
  output logic [W_V+1:0]   row
);
  localparam int CW_H = W_H + 2;
  localparam int CW_V = W_V + 2;

  // Shadow copies of the phase lengths, refreshed only at frame boundaries.
  logic [W_H-1:0] sh_h_act, sh_h_fp, sh_h_sync, sh_h_bp;
  logic [W_V-1:0] sh_v_act, sh_v_fp, sh_v_sync, sh_v_bp;

  logic            started;
  logic            hold_origin;
  logic            reload;
  logic [CW_H-1:0] h_nxt;
  logic [CW_V-1:0] v_nxt;
  logic            h_end, v_end;
  logic            h_nxt_act, h_nxt_sync, v_nxt_act, v_nxt_sync;
  logic            hs_q, vs_q, de_q, fs_q;
  launch_edge_e    sync_sel;
  logic [2:0]      launch_q;

  assign hold_origin = !(run && started);
  assign reload      = hold_origin || (h_end && v_end);

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      sh_h_act  <= h_act;
      sh_h_fp   <= h_fp;
      sh_h_sync <= h_sync;
      sh_h_bp   <= h_bp;
      sh_v_act  <= v_act;
      sh_v_fp   <= v_fp;
      sh_v_sync <= v_sync;
      sh_v_bp   <= v_bp;
    end
  end

  tgen_axis #(.CW(CW_H)) u_haxis (
    .clk      (clk),
    .rst      (rst),
    .clear    (hold_origin),
    .step     (1'b1),
    .len_act  ({2'b00, sh_h_act}),
    .len_fp   ({2'b00, sh_h_fp}),
    .len_sync ({2'b00, sh_h_sync}),
    .len_bp   ({2'b00, sh_h_bp}),
    .cnt      (col),
    .nxt      (h_nxt),
    .at_end   (h_end),
    .nxt_act  (h_nxt_act),
    .nxt_sync (h_nxt_sync)
  );

  tgen_axis #(.CW(CW_V)) u_vaxis (
    .clk      (clk),
    .rst      (rst),
    .clear    (hold_origin),
    .step     (h_end),
    .len_act  ({2'b00, sh_v_act}),
    .len_fp   ({2'b00, sh_v_fp}),
    .len_sync ({2'b00, sh_v_sync}),
    .len_bp   ({2'b00, sh_v_bp}),
    .cnt      (row),
    .nxt      (v_nxt),
    .at_end   (v_end),
    .nxt_act  (v_nxt_act),
    .nxt_sync (v_nxt_sync)
  );

  // Control levels registered on the rising edge, aligned with col/row.
  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      hs_q    <= ~pol_hs;
      vs_q    <= ~pol_vs;
      de_q    <= ~pol_de;
      fs_q    <= 1'b0;
    end else begin
      started <= run;
      hs_q    <= drive_level(run && h_nxt_sync, en_hs, pol_hs);
      vs_q    <= drive_level(run && v_nxt_sync, en_vs, pol_vs);
      de_q    <= drive_level(run && h_nxt_act && v_nxt_act, en_de, pol_de);
      fs_q    <= run && (h_nxt == '0) && (v_nxt == '0);
    end
  end

  assign sync_sel = launch_edge_e'(sync_edge_valid ? sync_edge : data_edge);

  tgen_launch #(.N(3)) u_launch (
    .clk     (clk),
    .rst     (rst),
    .d       ({hs_q, vs_q, de_q}),
    .rst_val ({~pol_hs, ~pol_vs, ~pol_de}),
    .on_rise ({sync_sel == EDGE_RISE, sync_sel == EDGE_RISE, data_edge}),
    .q       (launch_q)
  );

  assign hsync       = launch_q[2];
  assign vsync       = launch_q[1];
  assign de          = launch_q[0];
  assign frame_start = fs_q;
endmodule

// File: rtl/display_timing_gen_chk.sv
module display_timing_gen_chk #(
  parameter int CW_H = 14,
  parameter int CW_V = 13
) (
  input logic            clk,
  input logic            rst,
  input logic            run,
  input logic [CW_H-1:0] col,
  input logic [CW_V-1:0] row,
  input logic            frame_start,
  input logic            de_q,
  input logic            pol_de
);
  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (col != '0) |-> (col == $past(col) + CW_H'(1))); // R1

  AST_ROW_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (col != '0) |-> $stable(row)); // R3

  AST_FS_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (col == '0 && row == '0)); // R10

  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start); // R10

  AST_STOP_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    !run |=> (col == '0 && row == '0 && !frame_start)); // R11

  AST_STOP_DE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> (de_q == ~$past(pol_de))); // R11
endmodule

bind display_timing_gen display_timing_gen_chk #(.CW_H(CW_H), .CW_V(CW_V)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .run         (run),
  .col         (col),
  .row         (row),
  .frame_start (frame_start),
  .de_q        (de_q),
  .pol_de      (pol_de)
);

// File: tb/display_timing_gen_bench.sv
module display_timing_gen_bench;
  localparam int W_H = 12;
  localparam int W_V = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic [W_H-1:0] h_act = 4, h_fp = 2, h_sync = 3, h_bp = 1;
  logic [W_V-1:0] v_act = 3, v_fp = 1, v_sync = 2, v_bp = 2;
  logic pol_hs = 1, pol_vs = 1, pol_de = 1;
  logic en_hs = 1, en_vs = 1, en_de = 1;
  logic data_edge = 1, sync_edge = 1, sync_edge_valid = 1;
  logic hsync, vsync, de, frame_start;
  logic [W_H+1:0] col;
  logic [W_V+1:0] row;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  display_timing_gen #(.W_H(W_H), .W_V(W_V)) u_display_timing_gen (
    .clk(clk), .rst(rst), .run(run),
    .h_act(h_act), .h_fp(h_fp), .h_sync(h_sync), .h_bp(h_bp),
    .v_act(v_act), .v_fp(v_fp), .v_sync(v_sync), .v_bp(v_bp),
    .pol_hs(pol_hs), .pol_vs(pol_vs), .pol_de(pol_de),
    .en_hs(en_hs), .en_vs(en_vs), .en_de(en_de),
    .data_edge(data_edge), .sync_edge(sync_edge), .sync_edge_valid(sync_edge_valid),
    .hsync(hsync), .vsync(vsync), .de(de), .frame_start(frame_start),
    .col(col), .row(row)
  );

  // Config vectors: {pol_hs,pol_vs,pol_de, en_hs,en_vs,en_de, data_edge, sync_edge, sync_edge_valid}
  localparam logic [8:0] CFG_TAB [7] = '{
    9'b111_111_1_1_1,
    9'b000_111_1_0_0,
    9'b101_111_0_0_0,
    9'b010_111_0_1_1,
    9'b110_111_1_0_1,
    9'b111_010_1_1_1,
    9'b000_101_0_1_0
  };

  function automatic logic lvl(input bit asserted, input logic en, input logic pol);
    return (asserted && en) ? pol : !pol;
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    n_cmp++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic apply_cfg(input logic [8:0] c);
    {pol_hs, pol_vs, pol_de, en_hs, en_vs, en_de, data_edge, sync_edge, sync_edge_valid} = c;
  endtask

  // Runs from the origin for a number of cycles and compares every output.
  task automatic run_frame(input int ha, input int hf, input int hsl, input int hb,
                           input int va, input int vf, input int vsl, input int vb,
                           input int cycles);
    int ht, vt, hn, vn;
    bit srise;
    logic eh, ev, ed, ph, pv, pd;
    ht = ha + hf + hsl + hb;
    vt = va + vf + vsl + vb;
    srise = sync_edge_valid ? sync_edge : data_edge;
    ph = !pol_hs; pv = !pol_vs; pd = !pol_de;
    run = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      @(posedge clk); #1;
      hn = k % ht;
      vn = (k / ht) % vt;
      eh = lvl(hn >= ha + hf && hn < ha + hf + hsl, en_hs, pol_hs);
      ev = lvl(vn >= va + vf && vn < va + vf + vsl, en_vs, pol_vs);
      ed = lvl(hn < ha && vn < va, en_de, pol_de);
      check("R1 R12", int'(col), hn);
      check("R3 R12", int'(row), vn);
      check("R10", int'(frame_start), int'(hn == 0 && vn == 0));
      check("R2 R5 R6 R8", int'(hsync), int'(srise ? eh : ph));
      check("R3 R5 R6 R8", int'(vsync), int'(srise ? ev : pv));
      check("R4 R5 R6 R7", int'(de), int'(data_edge ? ed : pd));
      ph = eh; pv = ev; pd = ed;
    end
    run = 1'b0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    apply_cfg(CFG_TAB[0]);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    // R11: reset state
    check("R11", int'(col), 0);
    check("R11", int'(row), 0);
    check("R11", int'(frame_start), 0);
    check("R11", int'(hsync), 0);
    check("R11", int'(vsync), 0);
    check("R11", int'(de), 0);

    // Table walk: one full frame per configuration (10-pixel line, 8-line frame)
    for (int t = 0; t < 7; t++) begin
      apply_cfg(CFG_TAB[t]);
      repeat (3) @(posedge clk);
      #1;
      run_frame(4, 2, 3, 1, 3, 1, 2, 2, 80);
    end

    // R9: mid-frame length change only applies from the next frame
    apply_cfg(CFG_TAB[0]);
    repeat (2) @(posedge clk);
    #1 run = 1'b1;
    for (int k = 0; k < 100; k++) begin
      @(posedge clk); #1;
      check("R9", int'(col), (k < 80) ? k % 10 : (k - 80) % 11);
      check("R9", int'(row), (k < 80) ? k / 10 : (k - 80) / 11);
      if (k == 84) check("R9 R4", int'(de), 1);
      if (k == 20) h_act = 5;
    end
    run = 1'b0;
    @(posedge clk); #1;
    // R11: stopping returns to the origin with outputs inactive
    check("R11", int'(col), 0);
    check("R11", int'(row), 0);
    check("R11", int'(de), 0);
    check("R11", int'(frame_start), 0);
    h_act = 4;
    repeat (2) @(posedge clk);
    #1 run = 1'b1;
    repeat (26) @(posedge clk);
    #1 run = 1'b0;
    @(posedge clk); #1;
    check("R11", int'(col), 0);
    check("R11", int'(row), 0);
    check("R11", int'(hsync), 0);
    check("R11", int'(vsync), 0);
    check("R11", int'(de), 0);

    // R12: all phase lengths at the minimum
    h_act = 1; h_fp = 1; h_sync = 1; h_bp = 1;
    v_act = 1; v_fp = 1; v_sync = 1; v_bp = 1;
    repeat (3) @(posedge clk);
    #1;
    run_frame(1, 1, 1, 1, 1, 1, 1, 1, 32);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule